// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This block is a compact performance-monitoring unit for a processor core. It holds a small set of independent event counters (two by default, each 32 bits wide). Each counter picks the event it watches through an event code written into its own control register, and software reads the running value through a separate count register. The core feeds the unit a vector of one-cycle event pulses: instruction retired, unconditional branch, instruction-cache access and miss, operand-cache read access and miss. A reserved event code counts every clock cycle with no pulse at all.

Software drives the unit through a single-cycle register port with a word address, a write enable, write data and combinational read data. A shared status register reports a sticky overflow flag per counter and accepts a write-one clear strobe per counter. The expected bring-up order is: clear the counter, program its event code with the mode and enable bits, then set the start bit. Stopping and resuming every counter only needs the start bit. Disabling a counter writes zero to its event field and start bit.

Top module: `evt_perf_unit`

## Requirements
- R1: After reset every control register, every counter and every overflow flag is zero, so every register reads back as zero.
- R2: The control register of counter i sits at word address i. It stores the event code in bits 16:6, the start bit in bit 3, a mode bit in bit 1 and the enable bit in bit 0. All other bits read as zero, and the mode bit has no effect on counting.
- R3: The count register of counter i sits at word address 4+i and reads the counter zero-extended to the data width. Writes to it are ignored.
- R4: A counter adds one on each clock edge at which its enable bit and start bit are both set and its selected event is active. Event code 0x000 is active on every clock.
- R5: Event codes map onto the pulse vector as follows: 0x202 to bit 0 (instruction), 0x204 to bit 1 (branch), 0x029 to bit 2, 0x02a to bit 3, 0x031 to bit 4 and 0x032 to bit 5. Any other code counts nothing.
- R6: Clearing the start bit freezes the counter at its value, and setting it again resumes from that value. With the enable bit at zero, the counter does not advance even when the start bit is set.
- R7: The status register sits at word address 8. Writing 1 to bit 8*i+1 zeroes counter i and its overflow flag on that write's clock edge, taking priority over a coincident increment. The clear bit is not stored and reads as zero.
- R8: Bit 8*i+3 of the status register is the overflow flag of counter i. It is set when the counter wraps from all-ones to zero and stays set until that counter is cleared. Writing to it has no effect.
- R9: Status bits 0, 8, 16 and 24, and every other status bit that is not an overflow flag, read as zero. Writing ones to them changes no counter and no flag.
- R10: Clearing one counter leaves the value and flag of the other counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (4) | Word address of the register access |
| bus_wr | input | 1 | Write enable, one write per asserted cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for bus_addr |
| evt_pulse | input | 6 | One-cycle event pulses, bit positions as in R5 |

## Verification
The bench aims at a clear strobe that lands on the same edge as an event pulse. A design that let the increment win would read back 1 rather than 0. It runs a counter across its wrap with a narrowed counter width and checks that the overflow flag rises exactly at the wrap, survives both a write to the flag bit and further counting, and drops only on a clear. A flag that was writable or not sticky shows up there. It stops and restarts a counter while pulses keep arriving, where a design that reloaded or kept counting would read a different total, and it presents every mapped event under masks that hold only the wrong pulses, so a miswired decoder counts where it should read zero. Writes of ones to the reserved status bits and to a count register must leave all state as it was.

// File: rtl/epu_pkg.sv
package epu_pkg;

   // number of pulse-driven event sources
   localparam int EPU_NUM_SRC = 6;
   localparam int EPU_CODE_W  = 11;

   // event code assigned to each pulse index, index 0 in the low slot
   localparam logic [EPU_NUM_SRC-1:0][EPU_CODE_W-1:0] EPU_SRC_CODES = {
      11'h032,   // 5: operand-cache read miss
      11'h031,   // 4: operand-cache read access
      11'h02a,   // 3: instruction-cache miss
      11'h029,   // 2: instruction-cache access
      11'h204,   // 1: unconditional branch
      11'h202    // 0: instruction executed
   };

   // code that counts every clock without a pulse
   localparam logic [EPU_CODE_W-1:0] EPU_CYCLE_CODE = 11'h000;

   // control word layout
   localparam int EPU_CTL_EN    = 0;
   localparam int EPU_CTL_MODE  = 1;
   localparam int EPU_CTL_START = 3;
   localparam int EPU_CTL_EVLSB = 6;

   // status word layout, per counter lane of 8 bits
   localparam int EPU_LANE_W   = 8;
   localparam int EPU_LANE_CLR = 1;
   localparam int EPU_LANE_OVF = 3;

endpackage

// File: rtl/epu_evt_sel.sv
module epu_evt_sel
   import epu_pkg::*;
#(
   parameter int CODE_W       = EPU_CODE_W,
   parameter int NUM_SRC      = EPU_NUM_SRC,
   parameter bit CYCLE_EVT_EN = 1'b1
) (
   input  logic [CODE_W-1:0]  code_i,
   input  logic [NUM_SRC-1:0] pulse_i,
   output logic               hit_o
);

   logic [NUM_SRC-1:0] match;
   logic               cyc_hit;

   generate
      if (NUM_SRC != EPU_NUM_SRC) begin : g_bad_src
         $error("epu_evt_sel: NUM_SRC must equal the event table size");
      end
      if (CODE_W != EPU_CODE_W) begin : g_bad_code
         $error("epu_evt_sel: CODE_W must equal the event code width");
      end

      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         assign match[k] = (code_i == EPU_SRC_CODES[k]) & pulse_i[k];
      end

      if (CYCLE_EVT_EN) begin : g_cyc
         assign cyc_hit = (code_i == EPU_CYCLE_CODE);
      end else begin : g_nocyc
         assign cyc_hit = 1'b0;
      end
   endgenerate

   assign hit_o = (|match) | cyc_hit;

endmodule

// File: rtl/epu_ctl_reg.sv
module epu_ctl_reg
   import epu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CODE_W = EPU_CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] word_o,
   output logic [CODE_W-1:0] code_o,
   output logic              run_o
);

   localparam logic [DATA_W-1:0] EV_FIELD =
      DATA_W'(((64'd1 << CODE_W) - 64'd1) << EPU_CTL_EVLSB);
   localparam logic [DATA_W-1:0] KEEP_MASK = EV_FIELD
      | (DATA_W'(1) << EPU_CTL_START)
      | (DATA_W'(1) << EPU_CTL_MODE)
      | (DATA_W'(1) << EPU_CTL_EN);

   logic [DATA_W-1:0] ctl_q;

   generate
      if (EPU_CTL_EVLSB + CODE_W > DATA_W) begin : g_bad_w
         $error("epu_ctl_reg: event field does not fit the data word");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_i) begin
         ctl_q <= wdata_i & KEEP_MASK;
      end
   end

   assign word_o = ctl_q;
   assign code_o = ctl_q[EPU_CTL_EVLSB +: CODE_W];
   assign run_o  = ctl_q[EPU_CTL_EN] & ctl_q[EPU_CTL_START];

endmodule

// File: rtl/epu_counter.sv
module epu_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             at_top;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("epu_counter: CNT_W must be at least 2");
      end
   endgenerate

   assign at_top = &cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
         if (at_top) begin
            ovf_q <= 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

endmodule

// File: rtl/evt_perf_unit.sv
module evt_perf_unit
   import epu_pkg::*;
#(
   parameter int NUM_CNT      = 2,
   parameter int CNT_W        = 32,
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter int CNT_BASE     = 4,
   parameter int STAT_ADDR    = 8,
   parameter bit CYCLE_EVT_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic                   bus_wr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic [EPU_NUM_SRC-1:0] evt_pulse
);

   localparam int STAT_BITS = NUM_CNT * EPU_LANE_W;

   logic [NUM_CNT-1:0][DATA_W-1:0]     ctl_word;
   logic [NUM_CNT-1:0][EPU_CODE_W-1:0] ctl_code;
   logic [NUM_CNT-1:0]                 ctl_run;
   logic [NUM_CNT-1:0]                 evt_hit;
   logic [NUM_CNT-1:0]                 inc_vec;
   logic [NUM_CNT-1:0]                 clr_pulse;
   logic [NUM_CNT-1:0][CNT_W-1:0]      cnt_all;
   logic [NUM_CNT-1:0]                 ovf_vec;
   logic [DATA_W-1:0]                  stat_word;
   logic                               stat_wr;
   logic [DATA_W-1:0]                  wdata_unused;

   // elaboration-time parameter checks
   generate
      if (NUM_CNT < 1 || NUM_CNT > 4) begin : g_bad_num
         $error("evt_perf_unit: NUM_CNT must be 1 to 4");
      end
      if (CNT_W > DATA_W) begin : g_bad_cw
         $error("evt_perf_unit: CNT_W must not exceed DATA_W");
      end
      if (STAT_BITS > DATA_W) begin : g_bad_sw
         $error("evt_perf_unit: status lanes exceed DATA_W");
      end
      if (NUM_CNT > CNT_BASE || CNT_BASE + NUM_CNT > STAT_ADDR) begin : g_bad_map
         $error("evt_perf_unit: register windows overlap");
      end
      if (STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
         $error("evt_perf_unit: STAT_ADDR outside the address range");
      end
   endgenerate

   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
         logic ctl_wr;

         assign ctl_wr       = bus_wr && (bus_addr == ADDR_W'(i));
         assign clr_pulse[i] = stat_wr && bus_wdata[i*EPU_LANE_W + EPU_LANE_CLR];

         epu_ctl_reg #(
            .DATA_W (DATA_W),
            .CODE_W (EPU_CODE_W)
         ) ctl_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (ctl_wr),
            .wdata_i (bus_wdata),
            .word_o  (ctl_word[i]),
            .code_o  (ctl_code[i]),
            .run_o   (ctl_run[i])
         );

         epu_evt_sel #(
            .CODE_W       (EPU_CODE_W),
            .NUM_SRC      (EPU_NUM_SRC),
            .CYCLE_EVT_EN (CYCLE_EVT_EN)
         ) sel_i (
            .code_i  (ctl_code[i]),
            .pulse_i (evt_pulse),
            .hit_o   (evt_hit[i])
         );

         assign inc_vec[i] = ctl_run[i] & evt_hit[i];

         epu_counter #(
            .CNT_W (CNT_W)
         ) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_pulse[i]),
            .inc_i (inc_vec[i]),
            .cnt_o (cnt_all[i]),
            .ovf_o (ovf_vec[i])
         );
      end
   endgenerate

   // status word: only overflow flags are visible, everything else reads zero
   always_comb begin
      stat_word = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         stat_word[i*EPU_LANE_W + EPU_LANE_OVF] = ovf_vec[i];
      end
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (bus_addr == ADDR_W'(i)) begin
            bus_rdata = ctl_word[i];
         end
         if (bus_addr == ADDR_W'(CNT_BASE + i)) begin
            bus_rdata = DATA_W'(cnt_all[i]);
         end
      end
      if (bus_addr == ADDR_W'(STAT_ADDR)) begin
         bus_rdata = stat_word;
      end
   end

   // write-data bits that no status lane decodes
   assign wdata_unused = bus_wdata;

endmodule

// File: rtl/epu_checker.sv
module epu_checker #(
   parameter int NUM_CNT = 2,
   parameter int CNT_W   = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_CNT-1:0]            clr_i,
   input logic [NUM_CNT-1:0]            inc_i,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
   input logic [NUM_CNT-1:0]            ovf_i
);

   generate
      for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
         AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[i] |=> (cnt_i[i] == '0) && !ovf_i[i]);   // R7

         AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            inc_i[i] && !clr_i[i] |=> cnt_i[i] == CNT_W'($past(cnt_i[i]) + 1'b1));   // R4

         AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !inc_i[i] && !clr_i[i] |=> $stable(cnt_i[i]));   // R6

         AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_i[i] && !clr_i[i] |=> ovf_i[i]);   // R8

         AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            inc_i[i] && !clr_i[i] && (&cnt_i[i]) |=> ovf_i[i] && (cnt_i[i] == '0));   // R8

         AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            !ovf_i[i] && !(inc_i[i] && (&cnt_i[i])) |=> !ovf_i[i]);   // R8
      end
   endgenerate

endmodule

bind evt_perf_unit epu_checker #(
   .NUM_CNT (NUM_CNT),
   .CNT_W   (CNT_W)
) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .clr_i (clr_pulse),
   .inc_i (inc_vec),
   .cnt_i (cnt_all),
   .ovf_i (ovf_vec)
);

// File: tb/evt_perf_unit_tb_top.sv
module evt_perf_unit_tb_top;

   localparam int TB_CNT_W = 12;
   localparam int NVEC     = 10;
   localparam int RUN_LEN  = 5;

   logic        clk;
   logic        rst_n;
   logic [3:0]  bus_addr;
   logic        bus_wr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic [5:0]  evt_pulse;

   int n_chk;
   int n_bad;

   // vector: {event code[16:6], pulse mask[5:0]}
   localparam logic [NVEC-1:0][16:0] VEC = {
      {11'h7ff, 6'b111111},
      {11'h000, 6'b000000},
      {11'h203, 6'b111111},
      {11'h202, 6'b111110},
      {11'h032, 6'b100000},
      {11'h031, 6'b010000},
      {11'h02a, 6'b001000},
      {11'h029, 6'b000100},
      {11'h204, 6'b000010},
      {11'h202, 6'b000001}
   };

   evt_perf_unit #(.CNT_W(TB_CNT_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt_pulse (evt_pulse)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   // bench-side event map, from R5
   function automatic int map_bit(input logic [10:0] code);
      case (code)
         11'h202: map_bit = 0;
         11'h204: map_bit = 1;
         11'h029: map_bit = 2;
         11'h02a: map_bit = 3;
         11'h031: map_bit = 4;
         11'h032: map_bit = 5;
         default: map_bit = -1;
      endcase
   endfunction

   function automatic logic [31:0] ctl(input logic [10:0] code, input logic start,
                                       input logic en);
      ctl = {15'd0, code, 2'b00, start, 1'b0, 1'b1, en};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #3000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] r;
      n_chk     = 0;
      n_bad     = 0;
      rst_n     = 1'b0;
      bus_wr    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      evt_pulse = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), r);
         check("R1 reset read", r, 32'h0);
      end
      @(negedge clk);

      // table walk: R4, R5
      for (int v = 0; v < NVEC; v++) begin
         logic [10:0] code;
         logic [5:0]  mask;
         int          c;
         int          b;
         int          exp;
         code = VEC[v][16:6];
         mask = VEC[v][5:0];
         c    = v % 2;
         b    = map_bit(code);
         if (code == 11'h000)              exp = RUN_LEN + 1;
         else if (b >= 0 && mask[b])       exp = RUN_LEN;
         else                              exp = 0;
         wr(4'd8, 32'h1 << (8*c + 1));
         wr(4'(c), ctl(code, 1'b1, 1'b1));
         evt_pulse = mask;
         repeat (RUN_LEN) @(negedge clk);
         evt_pulse = '0;
         wr(4'(c), ctl(code, 1'b0, 1'b1));
         rd(4'(4 + c), r);
         check($sformatf("R4/R5 vector %0d code %h", v, code), r, 32'(exp));
         @(negedge clk);
      end

      // R2: field storage and masking
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, r);
      check("R2 control readback", r, 32'h0001_FFCB);
      @(negedge clk);
      wr(4'd0, 32'h0);
      rd(4'd0, r);
      check("R2 disable readback", r, 32'h0);
      @(negedge clk);

      // R6: halt and resume with pulses present
      wr(4'd8, 32'h0000_0202);
      wr(4'd0, ctl(11'h202, 1'b1, 1'b1));
      evt_pulse = 6'b000001;
      repeat (3) @(negedge clk);
      wr(4'd0, ctl(11'h202, 1'b0, 1'b1));   // stop edge still counts: 4
      repeat (5) @(negedge clk);
      rd(4'd4, r);
      check("R6 frozen while stopped", r, 32'd4);
      @(negedge clk);
      wr(4'd0, ctl(11'h202, 1'b1, 1'b1));   // start edge does not count
      repeat (2) @(negedge clk);
      evt_pulse = '0;
      rd(4'd4, r);
      check("R6 resumed from held value", r, 32'd6);
      @(negedge clk);
      wr(4'd0, ctl(11'h202, 1'b1, 1'b0));
      evt_pulse = 6'b000001;
      repeat (3) @(negedge clk);
      evt_pulse = '0;
      rd(4'd4, r);
      check("R6 enable low blocks counting", r, 32'd6);

      // R3: count register write ignored
      @(negedge clk);
      wr(4'd4, 32'h0000_0055);
      rd(4'd4, r);
      check("R3 count write ignored", r, 32'd6);
      @(negedge clk);

      // R7: clear beats coincident increment
      wr(4'd0, ctl(11'h202, 1'b1, 1'b1));
      evt_pulse = 6'b000001;
      repeat (3) @(negedge clk);
      wr(4'd8, 32'h0000_0002);
      evt_pulse = '0;
      rd(4'd4, r);
      check("R7 clear wins over increment", r, 32'd0);
      rd(4'd8, r);
      check("R7 clear bit not stored", r, 32'h0);
      @(negedge clk);
      wr(4'd0, 32'h0);

      // R10: counter 1 unaffected by clear of counter 0
      wr(4'd9 - 4'd8, ctl(11'h204, 1'b1, 1'b1));
      evt_pulse = 6'b000010;
      repeat (4) @(negedge clk);
      evt_pulse = '0;
      wr(4'd1, ctl(11'h204, 1'b0, 1'b1));
      wr(4'd8, 32'h0000_0002);
      rd(4'd5, r);
      check("R10 other counter kept", r, 32'd4);
      @(negedge clk);

      // R9: reserved status bits
      wr(4'd8, 32'h0101_0101);
      rd(4'd5, r);
      check("R9 reserved write no clear", r, 32'd4);
      rd(4'd8, r);
      check("R9 reserved bits read zero", r, 32'h0);
      @(negedge clk);

      // R8: wrap of counter 0 with a narrowed width
      wr(4'd8, 32'h0000_0002);
      wr(4'd0, ctl(11'h000, 1'b1, 1'b1));
      repeat ((1 << TB_CNT_W) - 1) @(negedge clk);
      rd(4'd8, r);
      check("R8 no flag before wrap", r, 32'h0);
      @(negedge clk);   // this edge is the wrap: total count 2^W after the start
      wr(4'd0, ctl(11'h000, 1'b0, 1'b1));
      rd(4'd4, r);
      check("R8 counter wrapped", r, 32'd1);
      rd(4'd8, r);
      check("R8 flag set on wrap", r, 32'h0000_0008);
      @(negedge clk);
      wr(4'd8, 32'h0000_0008);
      rd(4'd8, r);
      check("R8 flag write has no effect", r, 32'h0000_0008);
      @(negedge clk);
      wr(4'd0, ctl(11'h000, 1'b1, 1'b1));
      repeat (3) @(negedge clk);
      wr(4'd0, ctl(11'h000, 1'b0, 1'b1));
      rd(4'd8, r);
      check("R8 flag sticky while counting", r, 32'h0000_0008);
      @(negedge clk);
      wr(4'd8, 32'h0000_0002);
      rd(4'd8, r);
      check("R8 R7 clear drops flag", r, 32'h0);
      rd(4'd5, r);
      check("R10 counter 1 kept over wrap test", r, 32'd4);

      finish_run();
   end

endmodule